// File: doc/BRIEF.md
# Clock-Stop SPI Master Serial Port

This block is a serial port that masters an SPI link with a gated bit clock. The bit clock toggles only while a word is being shifted and otherwise rests at a selectable idle level. A host writes a parallel word into a holding register. When the word moves into the shift register, the block pulls its active-low select line down automatically. One full bit period later the first clock edge follows. The element is then shifted out MSB first, and the input line is captured in the same bit slots. Reception always runs alongside transmission, clocked and framed by the transmitter's own clock and select.

A divider fed by the system clock sets the bit period. Two configuration bits pick the clock polarity and whether data is offset by half a bit from the clock edges. The element length is programmable from 1 to the data width. Bring-up is done in a fixed order:

1. Hold the port in reset and write the configuration.
2. Release the clock generator.
3. Wait two bit periods.
4. Release the port.

If a second word is waiting when a transfer ends, the next transfer starts at once and the select line stays low.

Top module: `spi_cs_master`

## Requirements
- R1: The bit period is (1 + D) system clocks, where D is the latched divider value (a value of 0 acts as 1). Half-period ticks fall where the divider count equals 0 and where it equals floor((D+1)/2).
- R2: While no transfer is active, `sclk` rests at the latched idle level (`cfg_idle_high`). Each element of N bits produces exactly N clock pulses.
- R3: `sel_n` falls on the tick at which a word is loaded, which is half-step 0. The first clock edge comes at half-step 2, one bit period later. `sel_n` rises at half-step 2N+2 unless a back-to-back word follows.
- R4: Half-delay mode (`cfg_half_delay` = 1): bit k is driven at half-step 2k+1 and input is sampled at half-step 2k+2, on leading edges (idle-to-active).
- R5: No-delay mode (`cfg_half_delay` = 0): bit k is driven at half-step 2k+2, on the leading edge. Input is sampled at half-step 2k+3, on the trailing edge.
- R6: Bits leave MSB first, from bit N-1 down to bit 0, where N = `cfg_len_m1` + 1. `mosi_oe` is high from the drive of bit 0 until half-step 2N+2. `mosi` reads 0 whenever `mosi_oe` is low.
- R7: At half-step 2N+2, `rx_valid` pulses for one system clock. `rx_data` then holds the N sampled bits, with the first sampled bit at position N-1 and all bits above N-1 at zero.
- R8: `tx_ready` equals `xmit_en` AND (holding register empty). A `tx_wr` while `tx_ready` is low is dropped.
- R9: If a word is held at half-step 2N+2, it is loaded on that same tick and `sel_n` stays low.
- R10: The mode, polarity, divider and length are latched only while `xmit_en` is low. Changing them while `xmit_en` is high has no effect.
- R11: While `gen_en` is low, no ticks occur and no transfer starts. While `xmit_en` is low, the sequencer is cleared: `sel_n` is 1, the clock is idle, and `mosi_oe` is 0.
- R12: After reset, `sel_n`=1, `sclk`=0, `mosi_oe`=0, `rx_valid`=0 and `tx_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Clock generator release |
| xmit_en | input | 1 | Transmitter/receiver release |
| cfg_half_delay | input | 1 | 1: data offset half a bit from the clock |
| cfg_idle_high | input | 1 | Idle clock level |
| cfg_div | input | 8 | Divider value D |
| cfg_len_m1 | input | 5 | Element length minus one |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | 32 | Word to send |
| tx_ready | output | 1 | Holding register can accept a word |
| sclk | output | 1 | Serial clock |
| sel_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi (low = high impedance) |
| miso | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle word-received pulse |
| rx_data | output | 32 | Received word |

## Verification
Every output is registered, so each result appears one system clock after the tick or input edge that causes it. `tx_ready` is the one exception: it follows `xmit_en` in the same cycle. The bench model advances on the same edge as the design and is compared 2 ns after that edge, so expected and actual values refer to the same cycle. Directed checks watch `sclk` edges to recover the bit period, the pulse count and the data at the sampling edge of each mode. `miso` is looped back from `mosi`, either direct or inverted, so the received word is known in advance.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef struct packed {
    logic half_delay;
    logic idle_high;
  } mode_t;
endpackage

// File: rtl/spi_cs_cfg.sv
module spi_cs_cfg #(
  parameter int DIVW = 8,
  parameter int LW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xmit_en,
  input  spi_cs_pkg::mode_t    mode_in,
  input  logic [DIVW-1:0]      div_in,
  input  logic [LW-1:0]        len_in,
  output spi_cs_pkg::mode_t    mode_q,
  output logic [DIVW-1:0]      div_q,
  output logic [LW-1:0]        len_q
);
  logic shadow_en;
  assign shadow_en = ~xmit_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= DIVW'(1);
      len_q  <= '0;
    end else if (shadow_en) begin
      mode_q <= mode_in;
      div_q  <= div_in;
      len_q  <= len_in;
    end
  end

  // R10: shadow is frozen while the port runs
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xmit_en) && xmit_en) |-> ($stable(mode_q) && $stable(div_q) && $stable(len_q)));
endmodule

// File: rtl/spi_cs_bitclk.sv
module spi_cs_bitclk #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_en,
  input  logic [DIVW-1:0] div_q,
  output logic            tick
);
  logic [DIVW-1:0] cnt, cnt_nxt;
  logic [DIVW-1:0] eff_div;
  logic [DIVW:0]   half_w;
  logic [DIVW-1:0] half;

  assign eff_div = (div_q == '0) ? DIVW'(1) : div_q;
  assign half_w  = ({1'b0, eff_div} + (DIVW+1)'(1)) >> 1;
  assign half    = half_w[DIVW-1:0];
  assign tick    = gen_en && ((cnt == '0) || (cnt == half));

  always_comb begin
    if (!gen_en)              cnt_nxt = '0;
    else if (cnt >= eff_div)  cnt_nxt = '0;
    else                      cnt_nxt = cnt + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R11: held generator gives no ticks
  p_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !tick);
  // R1: counter never passes the divider value while running
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && $stable(div_q)) |-> (cnt <= eff_div));
endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              xmit_en,
  input  spi_cs_pkg::mode_t mode_q,
  input  logic [LW-1:0]     len_q,
  input  logic              tx_wr,
  input  logic [DW-1:0]     tx_data,
  input  logic              miso,
  output logic              tx_ready,
  output logic              sclk,
  output logic              sel_n,
  output logic              mosi,
  output logic              mosi_oe,
  output logic              rx_valid,
  output logic [DW-1:0]     rx_data
);
  localparam int HW = LW + 2;

  logic          busy, busy_n;
  logic [HW-1:0] h, h_n, h_inc, end_h, last_h;
  logic [DW-1:0] sreg, sreg_n, rsh, rsh_n, hold, hold_n, rxd_n;
  logic          pend, pend_n, sel_d, oe_n, act, act_n, rxv_n;

  assign last_h = HW'(len_q) * HW'(2) + HW'(2);
  assign end_h  = last_h + HW'(2);
  assign h_inc  = h + HW'(1);

  always_comb begin
    busy_n = busy;  h_n = h;      sreg_n = sreg;  rsh_n = rsh;
    hold_n = hold;  pend_n = pend; sel_d = sel_n; oe_n = mosi_oe;
    act_n  = act;   rxv_n = 1'b0;  rxd_n = rx_data;
    if (!xmit_en) begin
      busy_n = 1'b0; pend_n = 1'b0; sel_d = 1'b1;
      oe_n   = 1'b0; act_n  = 1'b0; h_n   = '0;
    end else begin
      if (tick) begin
        if (busy && (h_inc == end_h)) begin
          rxv_n = 1'b1; rxd_n = rsh; oe_n = 1'b0; act_n = 1'b0;
          if (pend) begin
            h_n = '0; sreg_n = hold; pend_n = 1'b0; rsh_n = '0;
          end else begin
            busy_n = 1'b0; sel_d = 1'b1;
          end
        end else if (busy) begin
          h_n   = h_inc;
          act_n = !h_inc[0] && (h_inc >= HW'(2)) && (h_inc <= last_h);
          if (mode_q.half_delay) begin
            if (h_inc[0] && (h_inc < last_h)) begin
              if (h_inc == HW'(1)) oe_n = 1'b1;
              else                 sreg_n = sreg << 1;
            end
            if (!h_inc[0] && (h_inc >= HW'(2)) && (h_inc <= last_h))
              rsh_n = {rsh[DW-2:0], miso};
          end else begin
            if (!h_inc[0] && (h_inc >= HW'(2)) && (h_inc <= last_h)) begin
              if (h_inc == HW'(2)) oe_n = 1'b1;
              else                 sreg_n = sreg << 1;
            end
            if (h_inc[0] && (h_inc >= HW'(3)))
              rsh_n = {rsh[DW-2:0], miso};
          end
        end else if (pend) begin
          busy_n = 1'b1; h_n = '0; sreg_n = hold; pend_n = 1'b0;
          sel_d  = 1'b0; rsh_n = '0; oe_n = 1'b0; act_n = 1'b0;
        end
      end
      if (tx_wr && !pend) begin
        pend_n = 1'b1; hold_n = tx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; h <= '0; sreg <= '0; rsh <= '0; hold <= '0;
      pend <= 1'b0; sel_n <= 1'b1; mosi_oe <= 1'b0; act <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      busy <= busy_n; h <= h_n; sreg <= sreg_n; rsh <= rsh_n; hold <= hold_n;
      pend <= pend_n; sel_n <= sel_d; mosi_oe <= oe_n; act <= act_n;
      rx_valid <= rxv_n; rx_data <= rxd_n;
    end
  end

  assign tx_ready = xmit_en && !pend;
  assign sclk     = act ^ mode_q.idle_high;
  assign mosi     = mosi_oe && sreg[len_q];

  // R2: clock idles when no transfer runs
  p_idle_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (sclk == mode_q.idle_high));
  // R7: receive flag is a single-cycle pulse
  p_rx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R6: data is only driven inside a frame
  p_oe_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mosi_oe |-> !sel_n);
  // R1: clock moves only on a divider tick
  p_sclk_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xmit_en) && xmit_en && !$past(tick)) |-> $stable(sclk));
  // R3: select falls with data not yet driven and clock idle
  p_start_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (!mosi_oe && (sclk == mode_q.idle_high)));
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int DW   = 32,
  parameter int DIVW = 8,
  parameter int LW   = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_en,
  input  logic            xmit_en,
  input  logic            cfg_half_delay,
  input  logic            cfg_idle_high,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [LW-1:0]   cfg_len_m1,
  input  logic            tx_wr,
  input  logic [DW-1:0]   tx_data,
  output logic            tx_ready,
  output logic            sclk,
  output logic            sel_n,
  output logic            mosi,
  output logic            mosi_oe,
  input  logic            miso,
  output logic            rx_valid,
  output logic [DW-1:0]   rx_data
);
  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic              tick;
  spi_cs_pkg::mode_t mode_in, mode_q;
  logic [DIVW-1:0]   div_q;
  logic [LW-1:0]     len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign mode_in.half_delay = cfg_half_delay;
  assign mode_in.idle_high  = cfg_idle_high;

  spi_cs_cfg #(.DIVW(DIVW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .xmit_en(xmit_en),
    .mode_in(mode_in), .div_in(cfg_div), .len_in(cfg_len_m1),
    .mode_q(mode_q), .div_q(div_q), .len_q(len_q));

  spi_cs_bitclk #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst_n(rst_i_n), .gen_en(gen_en), .div_q(div_q), .tick(tick));

  spi_cs_shifter #(.DW(DW), .LW(LW)) u_shf (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .xmit_en(xmit_en),
    .mode_q(mode_q), .len_q(len_q), .tx_wr(tx_wr), .tx_data(tx_data),
    .miso(miso), .tx_ready(tx_ready), .sclk(sclk), .sel_n(sel_n),
    .mosi(mosi), .mosi_oe(mosi_oe), .rx_valid(rx_valid), .rx_data(rx_data));
endmodule

// File: tb/spi_cs_master_tb.sv
`timescale 1ns/1ps
module spi_cs_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic gen_en = 0, xmit_en = 0, cfg_half_delay = 1, cfg_idle_high = 0;
  logic [7:0] cfg_div = 8'd3;
  logic [4:0] cfg_len_m1 = 5'd7;
  logic tx_wr = 0;
  logic [31:0] tx_data = '0;
  logic tx_ready, sclk, sel_n, mosi, mosi_oe, rx_valid, miso, inv = 0;
  logic [31:0] rx_data;

  always #5 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_cs_master u_dut (.clk(clk), .rst_n(rst_n), .gen_en(gen_en), .xmit_en(xmit_en),
    .cfg_half_delay(cfg_half_delay), .cfg_idle_high(cfg_idle_high), .cfg_div(cfg_div),
    .cfg_len_m1(cfg_len_m1), .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready),
    .sclk(sclk), .sel_n(sel_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso),
    .rx_valid(rx_valid), .rx_data(rx_data));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_h, m_div, m_len;
  bit m_busy, m_pend, m_sel, m_oe, m_act, m_rxv, m_dl, m_pol;
  logic [31:0] m_sreg, m_rsh, m_hold, m_rxd;
  int ediv, half, nb;
  bit tk;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_h = 0; m_busy = 0; m_pend = 0; m_sel = 1; m_oe = 0; m_act = 0;
      m_rxv = 0; m_sreg = 0; m_rsh = 0; m_hold = 0; m_rxd = 0;
      m_div = 1; m_len = 0; m_dl = 0; m_pol = 0;
    end else begin
      ediv = (m_div == 0) ? 1 : m_div;
      half = (ediv + 1) / 2;
      nb   = m_len + 1;
      tk   = gen_en && (m_cnt == 0 || m_cnt == half);
      m_cnt = !gen_en ? 0 : (m_cnt >= ediv ? 0 : m_cnt + 1);
      m_rxv = 0;
      if (!xmit_en) begin
        m_busy = 0; m_pend = 0; m_sel = 1; m_oe = 0; m_act = 0; m_h = 0;
        m_dl = cfg_half_delay; m_pol = cfg_idle_high; m_div = cfg_div; m_len = cfg_len_m1;
      end else begin
        bit was_pend;
        was_pend = m_pend;
        if (tk) begin
          if (m_busy && m_h + 1 == 2 * nb + 2) begin
            m_rxv = 1; m_rxd = m_rsh; m_oe = 0; m_act = 0;
            if (m_pend) begin m_h = 0; m_sreg = m_hold; m_pend = 0; m_rsh = 0; end
            else begin m_busy = 0; m_sel = 1; end
          end else if (m_busy) begin
            m_h = m_h + 1;
            m_act = (m_h % 2 == 0) && m_h >= 2 && m_h <= 2 * nb;
            if ((m_dl && m_h % 2 == 1 && m_h < 2 * nb) ||
                (!m_dl && m_h % 2 == 0 && m_h >= 2 && m_h <= 2 * nb)) begin
              if (m_h == (m_dl ? 1 : 2)) m_oe = 1; else m_sreg = m_sreg << 1;
            end
            if ((m_dl && m_h % 2 == 0 && m_h >= 2 && m_h <= 2 * nb) ||
                (!m_dl && m_h % 2 == 1 && m_h >= 3))
              m_rsh = {m_rsh[30:0], miso};
          end else if (m_pend) begin
            m_busy = 1; m_h = 0; m_sreg = m_hold; m_pend = 0; m_sel = 0;
            m_rsh = 0; m_oe = 0; m_act = 0;
          end
        end
        if (tx_wr && !was_pend) begin m_pend = 1; m_hold = tx_data; end
      end
    end
  end

  // per-cycle comparison and edge monitor
  bit cmp_on = 0, cur_dl = 1, cur_pol = 0, prev_sclk = 0;
  int cyc = 0, lead_cnt = 0, last_lead = -1, period = 0, ncap = 0, rx_cnt = 0, sel_rise = 0;
  logic [31:0] cap = 0, last_cap = 0, last_rx = 0;
  int last_pulses = 0, last_n = 0;
  bit prev_sel = 1, sel_at_rx = 1;
  always @(posedge clk) begin
    #2;
    cyc++;
    if (cmp_on) begin
      chk(sclk === (m_act ^ m_pol), "R2 sclk", sclk, m_act ^ m_pol);
      chk(sel_n === m_sel, "R3 sel_n", sel_n, m_sel);
      chk(mosi_oe === m_oe, "R6 mosi_oe", mosi_oe, m_oe);
      chk(mosi === (m_oe ? m_sreg[m_len] : 1'b0), "R4 R5 mosi", mosi, m_oe ? m_sreg[m_len] : 1'b0);
      chk(rx_valid === m_rxv, "R7 rx_valid", rx_valid, m_rxv);
      if (m_rxv) chk(rx_data === m_rxd, "R7 rx_data", rx_data, m_rxd);
      chk(tx_ready === (xmit_en && !m_pend), "R8 tx_ready", tx_ready, xmit_en && !m_pend);
    end
    if (prev_sclk == cur_pol && sclk != cur_pol) begin
      lead_cnt++;
      if (last_lead >= 0) period = cyc - last_lead;
      last_lead = cyc;
    end
    if (sclk != prev_sclk && ((cur_dl && sclk != cur_pol) || (!cur_dl && sclk == cur_pol))) begin
      cap = {cap[30:0], mosi}; ncap++;
    end
    if (sel_n && !prev_sel) sel_rise++;
    if (rx_valid) begin
      rx_cnt++; last_cap = cap; last_n = ncap; last_pulses = lead_cnt;
      last_rx = rx_data; sel_at_rx = sel_n;
      cap = 0; ncap = 0; lead_cnt = 0; last_lead = -1;
    end
    prev_sclk = sclk; prev_sel = sel_n;
  end

  bit wd_hit = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic put(input logic [31:0] w);
    @(negedge clk); tx_wr = 1; tx_data = w;
    @(negedge clk); tx_wr = 0;
  endtask
  task automatic put_ready(input logic [31:0] w);
    while (!tx_ready) @(negedge clk);
    tx_wr = 1; tx_data = w;
    @(negedge clk); tx_wr = 0;
  endtask
  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_cnt < n && t < 5000) begin @(posedge clk); t++; end
    #3;
  endtask
  task automatic setup(input bit dl, input bit pol, input logic [7:0] dv, input logic [4:0] ln);
    @(negedge clk); xmit_en = 0; gen_en = 0;
    cfg_half_delay = dl; cfg_idle_high = pol; cfg_div = dv; cfg_len_m1 = ln;
    cur_dl = dl; cur_pol = pol; prev_sclk = pol;
    @(negedge clk); gen_en = 1;
    repeat (2 * (int'(dv) + 1) + 2) @(negedge clk);
    xmit_en = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(sel_n === 1'b1, "R12 sel_n", sel_n, 1);
    chk(sclk === 1'b0, "R12 sclk", sclk, 0);
    chk(mosi_oe === 1'b0 && rx_valid === 1'b0, "R12 oe/rx_valid", {mosi_oe, rx_valid}, 0);
    chk(tx_ready === 1'b0, "R12 tx_ready", tx_ready, 0);
    cmp_on = 1;
    // R8 write while port held is dropped
    put(32'h5A);
    repeat (5) @(negedge clk);
    chk(tx_ready === 1'b0 && sel_n === 1'b1, "R8 write while held", {tx_ready, sel_n}, 2'b01);

    // Test A: half-delay, idle low, D=3, 8 bits
    setup(1, 0, 8'd3, 5'd7);
    put_ready(32'hA5);
    wait_rx(1);
    chk(last_cap == 32'hA5, "R4 R6 data at leading edges", last_cap, 32'hA5);
    chk(last_pulses == 8, "R2 pulse count", last_pulses, 8);
    chk(period == 4, "R1 bit period", period, 4);
    chk(last_rx == 32'hA5, "R7 loopback word", last_rx, 32'hA5);
    repeat (3) @(negedge clk);
    chk(sel_n === 1'b1 && sclk === 1'b0, "R3 select released, clock idle", {sel_n, sclk}, 2'b10);

    // Test B: no-delay, idle high, D=4, 16 bits, inverted loopback, back to back
    setup(0, 1, 8'd4, 5'd15);
    inv = 1;
    sel_rise = 0;
    put_ready(32'h1234);
    put_ready(32'hBEEF);
    @(negedge clk);
    cfg_div = 8'd9; cfg_idle_high = 0;   // ignored while running (R10)
    wait_rx(2);
    chk(last_cap == 32'h1234, "R5 data at trailing edges", last_cap, 32'h1234);
    chk(last_rx == 32'h0000EDCB, "R7 inverted word", last_rx, 32'hEDCB);
    chk(sel_at_rx === 1'b0, "R9 select held low between words", sel_at_rx, 0);
    wait_rx(3);
    chk(period == 5, "R10 divider change ignored", period, 5);
    chk(sel_rise == 1, "R9 single select release", sel_rise, 1);
    repeat (3) @(negedge clk);
    chk(sclk === 1'b1, "R10 polarity change ignored", sclk, 1);
    inv = 0;

    // Test C: generator held, second write dropped
    @(negedge clk); xmit_en = 0; gen_en = 0;
    cfg_half_delay = 1; cfg_idle_high = 0; cfg_div = 8'd2; cfg_len_m1 = 5'd3;
    cur_dl = 1; cur_pol = 0;
    @(negedge clk); xmit_en = 1;
    put(32'h9); put(32'h6);
    repeat (6) @(negedge clk);
    chk(sel_n === 1'b1, "R11 no start while generator held", sel_n, 1);
    chk(tx_ready === 1'b0, "R8 holding register full", tx_ready, 0);
    gen_en = 1;
    wait_rx(4);
    repeat (30) @(negedge clk);
    chk(rx_cnt == 4 && last_rx == 32'h9, "R8 only first word sent", last_rx, 32'h9);

    // Test D: 32 bits, D=0 acts as 1, idle high, half-delay
    setup(1, 1, 8'd0, 5'd31);
    put_ready(32'h8000_0001);
    wait_rx(5);
    chk(last_rx == 32'h8000_0001, "R6 R7 full-width word", last_rx, 32'h80000001);
    chk(period == 2, "R1 zero divider", period, 2);
    chk(last_pulses == 32, "R2 32 pulses", last_pulses, 32);

    // R11 abort mid-transfer
    put_ready(32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    xmit_en = 0;
    repeat (2) @(negedge clk);
    chk(sel_n === 1'b1 && mosi_oe === 1'b0, "R11 port held clears frame", {sel_n, mosi_oe}, 2'b10);
    repeat (4) @(negedge clk);

    if (!wd_hit) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule